// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

This block is one timer channel that shares a single 16-bit data register, reached as a low byte and a high byte, across three uses. In capture mode it records the value of an external free-running 16-bit timer when the channel input shows a chosen edge. In compare mode it watches that same timer and acts when the timer reaches the stored value. In PWM mode it produces a pulse train paced by a separate 8-bit period timer. A 4-bit mode field in a control byte picks the use, and software reaches the control byte and both data bytes through a small register port.

The channel has four named states: `ST_OFF`, `ST_CAPTURE`, `ST_COMPARE` and `ST_PWM`. The state is recomputed on every write to the control byte, from the new mode field: 0000–0011 take any state to `ST_OFF`, 01xx to `ST_CAPTURE`, 10xx to `ST_COMPARE` and 11xx to `ST_PWM`. With no control write the state holds. The low two mode bits then choose the sub-behaviour inside each state. The channel raises a sticky interrupt flag on every capture and every compare hit. In one compare variant it also sends one-cycle pulses that clear the 16-bit timer and ask an ADC to convert.

Top module: `tmr_ccp_channel`

## Requirements
- R1: After reset the control byte, both data bytes, the channel output, the interrupt flag, `timer_clear` and `adc_trigger` are all 0.
- R2: Read address 0 returns the control byte, with bits 7:6 always 0 and bits 5:0 as last written. Address 1 reads and writes the low data byte, and address 2 the high data byte. Writes take effect at the clock edge where `wr_en` is high.
- R3: Mode 0101 captures on each rising input edge and mode 0100 on each falling edge. An edge of the other polarity captures nothing. The input passes two synchronizing flops. For a change made before clock edge k, the data register loads the timer value present just before edge k+2, and the flag sets at that edge.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. Edges in between do not capture.
- R5: Any write that changes the mode field clears the edge prescaler count, so a prescaled capture again needs a full 4 or 16 edges.
- R6: Writing mode 1000 sets the output latch to 0, and writing mode 1001 sets it to 1. At the first edge where the timer equals the data register, 1000 drives the output to 1 and 1001 drives it to 0, and the flag sets.
- R7: Mode 1010 sets only the flag on a match. The output keeps the latch value held when the mode was entered.
- R8: Mode 1011 sets the flag on a match, leaves the output unchanged, and pulses `timer_clear` and `adc_trigger` high for exactly one cycle after the match edge.
- R9: Any mode 11xx is PWM. The 10-bit duty is {low data byte, control bits 5:4}. A 2-bit sub-count runs with the clock and restarts at each period wrap. The output rises at the wrap edge if the duty is nonzero and stays high for duty clocks. A duty of 0 keeps the output low, and a duty at or above the period length keeps it high for the whole period.
- R10: The PWM duty is loaded only at a period wrap. A change written mid-period first affects the next period.
- R11: Modes 0000–0011 drive the output low, clear the compare latch and stop all channel activity.
- R12: The interrupt flag stays set until `irq_clr`. A new event in the same cycle as `irq_clr` keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 low byte, 2 high byte |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Read data (combinational) |
| timer_val | input | 16 | Free-running 16-bit timer value |
| pwm_timer | input | 8 | 8-bit PWM period timer value |
| pwm_wrap | input | 1 | High in the last cycle of each PWM period |
| chan_in | input | 1 | Channel input pin (asynchronous) |
| chan_out | output | 1 | Channel output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| timer_clear | output | 1 | One-cycle request to clear the 16-bit timer |
| adc_trigger | output | 1 | One-cycle request to start a conversion |

## Verification
The bench times captures to the exact timer value two clocks after the input change. A design with one synchronizer flop too few or too many stores a value off by one. Prescaled modes get long edge trains, and a mode change lands partway through a count. A counter that is not cleared captures early, and one that never wraps captures only once. Compare runs check the output latch at mode entry and at the match edge, including the variants that must leave the pin alone and the special event's single-cycle pulses. PWM windows are counted clock by clock for a normal duty, a zero duty, a duty longer than the period and a mid-period duty change, which shows whether the double buffer loads too early.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_CAPTURE,
        ST_COMPARE,
        ST_PWM
    } ccp_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;

    function automatic ccp_state_e mode_to_state(input logic [3:0] mode);
        ccp_state_e st;
        unique case (mode[3:2])
            2'b00:   st = ST_OFF;
            2'b01:   st = ST_CAPTURE;
            2'b10:   st = ST_COMPARE;
            default: st = ST_PWM;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/ccp_capture_unit.sv
module ccp_capture_unit #(
    parameter int PRESC_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] sel,
    input  logic       clr_count,
    input  logic       pin,
    output logic       fire
);
    localparam logic [PRESC_W-1:0] LAST_FAST = PRESC_W'(3);
    localparam logic [PRESC_W-1:0] LAST_SLOW = '1;

    logic [2:0]         sync_q;
    logic [PRESC_W-1:0] cnt_q;
    logic               rise, fall, count_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pin};
    end

    assign rise      = sync_q[1] & ~sync_q[2];
    assign fall      = ~sync_q[1] & sync_q[2];
    assign count_hit = sel[0] ? (cnt_q == LAST_SLOW) : (cnt_q == LAST_FAST);

    always_comb begin
        unique case (sel)
            2'b00:   fire = enable & fall;
            2'b01:   fire = enable & rise;
            default: fire = enable & rise & count_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !enable || clr_count) cnt_q <= '0;
        else if (rise && sel[1])            cnt_q <= count_hit ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/ccp_compare_unit.sv
module ccp_compare_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [1:0]   sel,
    input  logic         arm,
    input  logic [1:0]   arm_sel,
    input  logic [W-1:0] timer,
    input  logic [W-1:0] value,
    output logic         hit,
    output logic         pin_q,
    output logic         event_q
);
    logic match, match_q;

    assign match = (timer == value);
    assign hit   = enable & match & ~match_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            pin_q   <= 1'b0;
            event_q <= 1'b0;
        end else begin
            match_q <= match;
            event_q <= hit && (sel == 2'b11);
            if (arm && !arm_sel[1]) pin_q <= arm_sel[0];
            else if (!enable)       pin_q <= 1'b0;
            else if (hit && !sel[1]) pin_q <= ~sel[0];
        end
    end

endmodule

// File: rtl/ccp_pwm_unit.sv
module ccp_pwm_unit #(
    parameter int TMR_W = 8,
    parameter int SUB_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   wrap,
    input  logic [TMR_W-1:0]       tmr,
    input  logic [TMR_W+SUB_W-1:0] duty_next,
    output logic                   pin_q
);
    localparam int DW = TMR_W + SUB_W;

    logic [SUB_W-1:0] sub_q;
    logic [DW-1:0]    duty_q;
    logic [DW-1:0]    ext;

    assign ext = {tmr, sub_q};

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            sub_q  <= '0;
            duty_q <= '0;
            pin_q  <= 1'b0;
        end else if (wrap) begin
            sub_q  <= '0;
            duty_q <= duty_next;
            pin_q  <= (duty_next != '0);
        end else begin
            sub_q <= sub_q + 1'b1;
            if (pin_q && ext == duty_q - DW'(1)) pin_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_ccp_channel.sv
module tmr_ccp_channel #(
    parameter int BYTE_W  = 8,
    parameter int PRESC_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [1:0]          rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic [2*BYTE_W-1:0] timer_val,
    input  logic [BYTE_W-1:0]   pwm_timer,
    input  logic                pwm_wrap,
    input  logic                chan_in,
    output logic                chan_out,
    output logic                irq_flag,
    input  logic                irq_clr,
    output logic                timer_clear,
    output logic                adc_trigger
);
    import ccp_pkg::*;

    localparam int DATA_W = 2 * BYTE_W;
    localparam int SUB_W  = 2;
    localparam int DUTY_W = BYTE_W + SUB_W;

    ccp_state_e        state_q, state_d;
    logic [3:0]        mode_q;
    logic [SUB_W-1:0]  dlsb_q;
    logic [DATA_W-1:0] data_q;
    logic [DUTY_W-1:0] duty_next;
    logic              wr_ctrl, mode_chg, cmp_arm;
    logic              cap_fire, cmp_hit, cmp_pin, cmp_event, pwm_pin;
    logic              irq_q;
    logic              unused_wr_hi;

    assign unused_wr_hi = &{1'b0, wr_data[BYTE_W-1:6]};
    assign wr_ctrl      = wr_en && (wr_addr == ADDR_CTRL);
    assign mode_chg     = wr_ctrl && (wr_data[3:0] != mode_q);
    assign cmp_arm      = mode_chg && (mode_to_state(wr_data[3:0]) == ST_COMPARE);
    assign duty_next    = {data_q[BYTE_W-1:0], dlsb_q};

    // state register and its next-state logic
    always_comb begin
        state_d = state_q;
        if (wr_ctrl) state_d = mode_to_state(wr_data[3:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // registers reached by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dlsb_q <= '0;
            data_q <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= wr_data[3:0];
                dlsb_q <= wr_data[5:4];
            end
            if (cap_fire) data_q <= timer_val;
            else if (wr_en && wr_addr == ADDR_LO) data_q[BYTE_W-1:0] <= wr_data;
            else if (wr_en && wr_addr == ADDR_HI) data_q[DATA_W-1:BYTE_W] <= wr_data;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = BYTE_W'({dlsb_q, mode_q});
            ADDR_LO:   rd_data = data_q[BYTE_W-1:0];
            ADDR_HI:   rd_data = data_q[DATA_W-1:BYTE_W];
            default:   rd_data = '0;
        endcase
    end

    ccp_capture_unit #(.PRESC_W(PRESC_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (state_q == ST_CAPTURE),
        .sel       (mode_q[1:0]),
        .clr_count (mode_chg),
        .pin       (chan_in),
        .fire      (cap_fire)
    );

    ccp_compare_unit #(.W(DATA_W)) u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (state_q == ST_COMPARE),
        .sel     (mode_q[1:0]),
        .arm     (cmp_arm),
        .arm_sel (wr_data[1:0]),
        .timer   (timer_val),
        .value   (data_q),
        .hit     (cmp_hit),
        .pin_q   (cmp_pin),
        .event_q (cmp_event)
    );

    ccp_pwm_unit #(.TMR_W(BYTE_W), .SUB_W(SUB_W)) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (state_q == ST_PWM),
        .wrap      (pwm_wrap),
        .tmr       (pwm_timer),
        .duty_next (duty_next),
        .pin_q     (pwm_pin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  irq_q <= 1'b0;
        else if (cap_fire || cmp_hit) irq_q <= 1'b1;
        else if (irq_clr)            irq_q <= 1'b0;
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_COMPARE: chan_out = cmp_pin;
            ST_PWM:     chan_out = pwm_pin;
            default:    chan_out = 1'b0;
        endcase
        irq_flag    = irq_q;
        timer_clear = cmp_event;
        adc_trigger = cmp_event;
    end

endmodule

// File: rtl/ccp_channel_checker.sv
module ccp_channel_checker #(
    parameter int BYTE_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           wr_addr,
    input logic [3:0]           wr_mode,
    input logic                 irq_flag,
    input logic                 irq_clr,
    input logic                 timer_clear,
    input logic                 chan_out,
    input logic                 pwm_wrap,
    input logic [2*BYTE_W-1:0]  timer_val,
    input ccp_pkg::ccp_state_e  state_q,
    input logic                 cap_fire,
    input logic [2*BYTE_W-1:0]  data_q,
    input logic [BYTE_W+1:0]    duty_next
);
    AST_CAPTURE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> data_q == $past(timer_val)); // R3
    AST_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> irq_flag); // R3
    AST_SPECIAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clear |=> !timer_clear); // R8
    AST_SPECIAL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clear |-> irq_flag); // R8
    AST_PWM_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ccp_pkg::ST_PWM && pwm_wrap && !wr_en && duty_next == '0) |=> !chan_out); // R9
    AST_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_mode[3:2] == 2'b00) |=> !chan_out); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag); // R12
endmodule

bind tmr_ccp_channel ccp_channel_checker #(.BYTE_W(BYTE_W)) u_ccp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_mode     (wr_data[3:0]),
    .irq_flag    (irq_flag),
    .irq_clr     (irq_clr),
    .timer_clear (timer_clear),
    .chan_out    (chan_out),
    .pwm_wrap    (pwm_wrap),
    .timer_val   (timer_val),
    .state_q     (state_q),
    .cap_fire    (cap_fire),
    .data_q      (data_q),
    .duty_next   (duty_next)
);

// File: tb/test_tmr_ccp_channel.sv
module test_tmr_ccp_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [1:0]  rd_addr, drv_addr = 2'd0, mon_addr = 2'd0;
    logic [7:0]  rd_data;
    logic [15:0] timer_val;
    logic [7:0]  pwm_timer;
    logic        pwm_wrap;
    logic        chan_in = 1'b0;
    logic        chan_out, irq_flag, irq_clr, timer_clear, adc_trigger;
    logic        clr_req = 1'b0, mon_clr = 1'b0;
    logic [4:0]  pcnt;
    bit          cap_mon = 1'b0, pwm_mon = 1'b0;
    string       cap_tag = "R3";
    int          checks = 0, errors = 0;

    logic [15:0] cap_q[$];
    int          pwm_q[$];
    string       pwm_tag_q[$];

    always #10 clk = ~clk;

    assign rd_addr   = cap_mon ? mon_addr : drv_addr;
    assign irq_clr   = clr_req | mon_clr;
    assign pwm_timer = {3'b000, pcnt[4:2]};
    assign pwm_wrap  = (pcnt == 5'd31);

    always @(posedge clk) begin
        if (!rst_n)           timer_val <= 16'd0;
        else if (timer_clear) timer_val <= 16'd0;
        else                  timer_val <= timer_val + 16'd1;
        if (!rst_n) pcnt <= 5'd0;
        else        pcnt <= pcnt + 5'd1;
    end

    tmr_ccp_channel i_tmr_ccp_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .timer_val(timer_val), .pwm_timer(pwm_timer),
        .pwm_wrap(pwm_wrap), .chan_in(chan_in), .chan_out(chan_out), .irq_flag(irq_flag),
        .irq_clr(irq_clr), .timer_clear(timer_clear), .adc_trigger(adc_trigger)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        drv_addr = a;
        #1 d = rd_data;
    endtask

    task automatic clear_flag();
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
    endtask

    // capture driver: pushes the expected captured timer value
    task automatic pin_edge(input logic level, input bit expect_cap);
        @(negedge clk);
        chan_in = level;
        if (expect_cap) cap_q.push_back(timer_val + 16'd2);
        repeat (9) @(negedge clk);
    endtask

    // capture monitor
    always @(negedge clk) begin
        logic [7:0] lo, hi;
        if (cap_mon && irq_flag && !mon_clr) begin
            mon_addr = 2'd1; #1 lo = rd_data;
            mon_addr = 2'd2; #1 hi = rd_data;
            if (cap_q.size() == 0) check({cap_tag, " unexpected capture"}, {hi, lo}, 32'hFFFFFFFF);
            else                   check({cap_tag, " captured value"}, {hi, lo}, cap_q.pop_front());
            mon_clr = 1'b1;
        end else begin
            mon_clr = 1'b0;
        end
    end

    // PWM monitor: high clocks per period
    int hcnt = 0;
    always @(negedge clk) begin
        if (!pwm_mon) hcnt = 0;
        else begin
            hcnt += int'(chan_out);
            if (pwm_wrap) begin
                if (pwm_q.size() != 0) check(pwm_tag_q.pop_front(), hcnt, pwm_q.pop_front());
                hcnt = 0;
            end
        end
    end

    task automatic pwm_windows(input int e1, input int e2, input string tag, input bit mid_change);
        do @(negedge clk); while (!pwm_wrap);
        pwm_q.push_back(e1); pwm_tag_q.push_back(tag);
        pwm_q.push_back(e2); pwm_tag_q.push_back(tag);
        @(posedge clk);
        pwm_mon = 1'b1;
        if (mid_change) begin
            repeat (3) @(negedge clk);
            wr(2'd1, 8'd0);
            wr(2'd0, 8'h1C);      // duty {0, 01} = 1
        end
        while (pwm_q.size() != 0) begin @(negedge clk); #2; end
        pwm_mon = 1'b0;
    endtask

    task automatic cmp_run(input logic [3:0] mode, input string tag, input logic entry_pin,
                           input logic hit_pin, input bit special);
        logic [15:0] tgt;
        int n;
        clear_flag();
        tgt = timer_val + 16'd40;
        wr(2'd1, tgt[7:0]);
        wr(2'd2, tgt[15:8]);
        wr(2'd0, {4'b0000, mode});
        check({tag, " pin on entry"}, chan_out, entry_pin);
        n = 0;
        while (!irq_flag && n < 200) begin @(negedge clk); n++; end
        check({tag, " flag on match"}, irq_flag, 1'b1);
        check({tag, " pin after match"}, chan_out, hit_pin);
        check({tag, " match timing"}, timer_val, tgt + 16'd1);
        if (special) begin
            check({tag, " pulses high"}, {timer_clear, adc_trigger}, 2'b11);
            @(negedge clk);
            check({tag, " pulses one cycle"}, {timer_clear, adc_trigger}, 2'b00);
            check({tag, " timer cleared"}, timer_val, 16'd0);
        end else begin
            check({tag, " no pulses"}, {timer_clear, adc_trigger}, 2'b00);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check("R1 outputs after reset", {chan_out, irq_flag, timer_clear, adc_trigger}, 4'b0000);
        rd(2'd0, v); check("R1 control after reset", v, 8'h00);
        rd(2'd1, v); check("R1 low byte after reset", v, 8'h00);
        rd(2'd2, v); check("R1 high byte after reset", v, 8'h00);

        // R2 register access
        wr(2'd0, 8'hF3);
        rd(2'd0, v); check("R2 control readback upper bits zero", v, 8'h33);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
        rd(2'd1, v); check("R2 low byte", v, 8'hA5);
        rd(2'd2, v); check("R2 high byte", v, 8'h3C);

        // R3 capture edges
        cap_mon = 1'b1;
        cap_tag = "R3";
        wr(2'd0, 8'h05);
        pin_edge(1'b1, 1'b1); pin_edge(1'b0, 1'b0); pin_edge(1'b1, 1'b1); pin_edge(1'b0, 1'b0);
        wr(2'd0, 8'h04);
        pin_edge(1'b1, 1'b0); pin_edge(1'b0, 1'b1);
        check("R3 all captures seen", cap_q.size(), 0);

        // R4 prescaled capture
        cap_tag = "R4";
        wr(2'd0, 8'h06);
        for (int i = 0; i < 8; i++) begin pin_edge(1'b1, (i % 4) == 3); pin_edge(1'b0, 1'b0); end
        wr(2'd0, 8'h07);
        for (int i = 0; i < 16; i++) begin pin_edge(1'b1, i == 15); pin_edge(1'b0, 1'b0); end
        check("R4 all captures seen", cap_q.size(), 0);

        // R5 mode change clears prescaler
        cap_tag = "R5";
        wr(2'd0, 8'h06);
        for (int i = 0; i < 2; i++) begin pin_edge(1'b1, 1'b0); pin_edge(1'b0, 1'b0); end
        wr(2'd0, 8'h07);
        wr(2'd0, 8'h06);
        for (int i = 0; i < 4; i++) begin pin_edge(1'b1, i == 3); pin_edge(1'b0, 1'b0); end
        check("R5 all captures seen", cap_q.size(), 0);
        cap_mon = 1'b0;

        // R6, R7, R8 compare variants
        wr(2'd0, 8'h00);
        cmp_run(4'b1001, "R6 clear-on-match", 1'b1, 1'b0, 1'b0);
        cmp_run(4'b1000, "R6 set-on-match", 1'b0, 1'b1, 1'b0);
        cmp_run(4'b1010, "R7 flag-only", 1'b1, 1'b1, 1'b0);
        // R12 sticky flag
        repeat (3) @(negedge clk);
        check("R12 flag held without clear", irq_flag, 1'b1);
        clear_flag();
        check("R12 flag cleared", irq_flag, 1'b0);
        cmp_run(4'b1011, "R8 special event", 1'b1, 1'b1, 1'b1);

        // R11 off mode
        wr(2'd0, 8'h00);
        check("R11 pin low in off mode", chan_out, 1'b0);
        wr(2'd0, 8'h0A);
        check("R11 latch cleared by off mode", chan_out, 1'b0);
        wr(2'd0, 8'h00);

        // R9, R10 PWM
        wr(2'd1, 8'd2); wr(2'd0, 8'h2C);            // duty 10
        pwm_windows(10, 10, "R9 duty 10 high clocks", 1'b0);
        wr(2'd1, 8'd2); wr(2'd0, 8'h2C);
        pwm_windows(10, 1, "R10 duty change waits for wrap", 1'b1);
        wr(2'd1, 8'd0); wr(2'd0, 8'h0C);            // duty 0
        pwm_windows(0, 0, "R9 duty zero", 1'b0);
        wr(2'd1, 8'd50);                            // duty 200 > period
        pwm_windows(32, 32, "R9 duty beyond period", 1'b0);
        wr(2'd0, 8'h00);
        check("R11 pin low after PWM off", chan_out, 1'b0);

        finish_run();
    end
endmodule